// File: doc/BRIEF.md
# Signature Race Checker

This block is a shared on-chip checker that looks for possible data races between threads. At each synchronization point a processor sends one record. The record holds a vector timestamp and two access signatures: a read set and a write set, each a bit vector built by hashing addresses. The checker keeps a bounded history of records for every thread. It compares each new record against the history of every other thread, including threads that have gone quiet.

Two records are concurrent when neither vector timestamp dominates the other. For a concurrent pair, the checker intersects the signatures. Three intersections count: the new reads against the old writes, the new writes against the old writes, and the new writes against the old reads. Any non-empty result is reported as a possible race, together with the conflict bits. When the checker meets the first ordered record in a thread's history, it stops walking that history, because every older entry is then also ordered. Each thread keeps sticky race and overflow flags and an accumulated conflict signature, so that system software can save and restore them on a context switch.

The walk runs in the background while senders are held off through the ready handshake. It visits one history entry per clock cycle, reading from a single block memory.

Top module: `sigrace_detector`

## Requirements
- R1: After reset, in_ready is 1, race_valid is 0, and race_flag, ovf_flag and conf_sig are all zero.
- R2: A record is accepted on a clock edge where in_valid and in_ready are both 1. In the cycle after acceptance in_ready is 0, and it stays 0 until the record has been checked and stored.
- R3: For a concurrent pair, the conflict signature is (new_read & old_write) | (new_write & old_write) | (new_write & old_read). A report is made only when this value is non-zero. Records whose signatures are empty never raise a report.
- R4: in_ts is NUM_THREADS fields of CLK_W bits each, with thread t in bits [t*CLK_W +: CLK_W]. Two records are ordered when every field of one is less than or equal to the matching field of the other. An ordered history entry produces no report and ends the walk of that thread, so older entries of that thread are not checked.
- R5: Histories are walked in ascending thread id, skipping the sender's own thread. Within each history the walk runs from the newest entry to the oldest. Threads that have sent nothing recently are still walked.
- R6: Each hit gives a one-cycle race_valid pulse. During the pulse, race_tid is the sender, race_peer is the thread whose entry conflicted, and race_sig is the conflict signature. The pulses come out in walk order.
- R7: On a hit, race_flag[race_tid] becomes 1, and the sender's slice of conf_sig (bits [tid*SIG_W +: SIG_W]) is ORed with race_sig. Both stay set until reset.
- R8: Each thread's history holds QDEPTH records. Storing into a full history drops the oldest record and sets that thread's ovf_flag, which stays set until reset. A dropped record is never checked again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Record offered |
| in_ready | output | 1 | Checker idle; a record can be taken |
| in_tid | input | $clog2(NUM_THREADS) | Sending thread |
| in_ts | input | NUM_THREADS*CLK_W | Vector timestamp of the record |
| in_rsig | input | SIG_W | Read-set signature |
| in_wsig | input | SIG_W | Write-set signature |
| race_valid | output | 1 | Possible race reported this cycle |
| race_tid | output | $clog2(NUM_THREADS) | Thread that sent the new record |
| race_peer | output | $clog2(NUM_THREADS) | Thread whose stored record conflicted |
| race_sig | output | SIG_W | Conflict signature of this hit |
| race_flag | output | NUM_THREADS | Sticky per-thread race flag |
| ovf_flag | output | NUM_THREADS | Sticky per-thread history overflow flag |
| conf_sig | output | NUM_THREADS*SIG_W | Accumulated conflict signature per thread |

## Verification
The bench builds the checker with four threads, a history depth of four, 16-bit signatures and 4-bit clock fields. With a depth of four, a few records from one thread are enough to overflow its history and drop an entry that would otherwise conflict. With four threads, a single walk crosses several peers, so the ordering of reports across threads and within one history is observable. The narrow clock fields make it easy to build ordered, concurrent and dominated timestamps by hand, including an ordered newest entry that hides a conflicting older one.

// File: rtl/sigrace_pkg.sv
package sigrace_pkg;
  typedef enum logic [1:0] {
    SCAN_IDLE = 2'd0,
    SCAN_WALK = 2'd1,
    SCAN_PUSH = 2'd2
  } walk_state_e;
endpackage

// File: rtl/sr_conflict.sv
// Pure compare of an incoming record against one stored record.
module sr_conflict #(
  parameter int NUM_THREADS = 4,
  parameter int CLK_W       = 8,
  parameter int SIG_W       = 64
) (
  input  logic [NUM_THREADS*CLK_W-1:0] in_ts,
  input  logic [SIG_W-1:0]             in_r,
  input  logic [SIG_W-1:0]             in_w,
  input  logic [NUM_THREADS*CLK_W-1:0] q_ts,
  input  logic [SIG_W-1:0]             q_r,
  input  logic [SIG_W-1:0]             q_w,
  output logic                         ordered,
  output logic                         hit,
  output logic [SIG_W-1:0]             sig
);
  logic [NUM_THREADS-1:0] q_le_in;
  logic [NUM_THREADS-1:0] in_le_q;

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_field
    assign q_le_in[g] = q_ts[g*CLK_W +: CLK_W] <= in_ts[g*CLK_W +: CLK_W];
    assign in_le_q[g] = in_ts[g*CLK_W +: CLK_W] <= q_ts[g*CLK_W +: CLK_W];
  end

  assign ordered = (&q_le_in) || (&in_le_q);
  assign sig     = (in_r & q_w) | (in_w & q_w) | (in_w & q_r);
  assign hit     = |sig;
endmodule

// File: rtl/sr_ptr_bank.sv
// Per-thread write pointer and occupancy of the circular histories.
module sr_ptr_bank #(
  parameter int NUM_THREADS = 4,
  parameter int QDEPTH      = 16,
  parameter int TID_W       = 2,
  parameter int PTR_W       = 4,
  parameter int CNT_W       = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [TID_W-1:0]             push_tid,
  output logic [NUM_THREADS*PTR_W-1:0] wptr_flat,
  output logic [NUM_THREADS*CNT_W-1:0] cnt_flat
);
  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_thr
    logic [PTR_W-1:0] wp;
    logic [CNT_W-1:0] n;
    always_ff @(posedge clk) begin
      if (rst) begin
        wp <= '0;
        n  <= '0;
      end else if (push && push_tid == TID_W'(g)) begin
        wp <= wp + PTR_W'(1);
        if (n != CNT_W'(QDEPTH)) n <= n + CNT_W'(1);
      end
    end
    assign wptr_flat[g*PTR_W +: PTR_W] = wp;
    assign cnt_flat[g*CNT_W +: CNT_W]  = n;
  end
endmodule

// File: rtl/sr_entry_ram.sv
// Simple dual-port memory with registered read, one slot per history entry.
module sr_entry_ram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 160
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/sigrace_detector.sv
module sigrace_detector #(
  parameter int NUM_THREADS = 4,
  parameter int QDEPTH      = 16,
  parameter int SIG_W       = 64,
  parameter int CLK_W       = 8
) (
  input  logic                                                 clk,
  input  logic                                                 rst,
  input  logic                                                 in_valid,
  output logic                                                 in_ready,
  input  logic [((NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1)-1:0] in_tid,
  input  logic [NUM_THREADS*CLK_W-1:0]                         in_ts,
  input  logic [SIG_W-1:0]                                     in_rsig,
  input  logic [SIG_W-1:0]                                     in_wsig,
  output logic                                                 race_valid,
  output logic [((NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1)-1:0] race_tid,
  output logic [((NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1)-1:0] race_peer,
  output logic [SIG_W-1:0]                                     race_sig,
  output logic [NUM_THREADS-1:0]                               race_flag,
  output logic [NUM_THREADS-1:0]                               ovf_flag,
  output logic [NUM_THREADS*SIG_W-1:0]                         conf_sig
);
  import sigrace_pkg::*;

  localparam int TID_W  = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1;
  localparam int PTR_W  = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int CNT_W  = PTR_W + 1;
  localparam int TS_W   = NUM_THREADS * CLK_W;
  localparam int ENT_W  = TS_W + 2 * SIG_W;
  localparam int ADDR_W = TID_W + PTR_W;

  walk_state_e st;

  logic [TID_W-1:0] rec_tid;
  logic [TS_W-1:0]  rec_ts;
  logic [SIG_W-1:0] rec_r, rec_w;

  logic [TID_W-1:0] cur_t;
  logic [CNT_W-1:0] cur_k;
  logic             pend, pend_last;
  logic [TID_W-1:0] pend_peer;

  logic [NUM_THREADS*PTR_W-1:0] wptr_flat;
  logic [NUM_THREADS*CNT_W-1:0] cnt_flat;

  logic [PTR_W-1:0] thr_wptr, own_wptr, rd_slot;
  logic [CNT_W-1:0] thr_cnt, own_cnt, eff_cnt;
  logic             can_issue, end_thr, thr_done, last_thr, hit_now;
  logic             rd_en, push;
  logic [ENT_W-1:0] rdata;
  logic [TS_W-1:0]  q_ts;
  logic [SIG_W-1:0] q_r, q_w, cmp_sig;
  logic             cmp_ordered, cmp_hit;

  // Walk bookkeeping for the thread currently being visited
  assign thr_wptr  = wptr_flat[cur_t*PTR_W +: PTR_W];
  assign thr_cnt   = cnt_flat[cur_t*CNT_W +: CNT_W];
  assign own_wptr  = wptr_flat[rec_tid*PTR_W +: PTR_W];
  assign own_cnt   = cnt_flat[rec_tid*CNT_W +: CNT_W];
  assign eff_cnt   = (cur_t == rec_tid) ? '0 : thr_cnt;
  assign rd_slot   = thr_wptr - PTR_W'(1) - cur_k[PTR_W-1:0];

  assign end_thr   = pend && (cmp_ordered || pend_last);
  assign can_issue = !end_thr && (cur_k < eff_cnt);
  assign thr_done  = end_thr || (!pend && !can_issue);
  assign last_thr  = (cur_t == TID_W'(NUM_THREADS - 1));
  assign hit_now   = (st == SCAN_WALK) && pend && !cmp_ordered && cmp_hit;
  assign rd_en     = (st == SCAN_WALK) && !thr_done;
  assign push      = (st == SCAN_PUSH);

  assign in_ready  = (st == SCAN_IDLE);

  assign q_ts = rdata[ENT_W-1 -: TS_W];
  assign q_r  = rdata[2*SIG_W-1 : SIG_W];
  assign q_w  = rdata[SIG_W-1 : 0];

  sr_ptr_bank #(
    .NUM_THREADS(NUM_THREADS), .QDEPTH(QDEPTH),
    .TID_W(TID_W), .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) u_ptrs (
    .clk(clk), .rst(rst), .push(push), .push_tid(rec_tid),
    .wptr_flat(wptr_flat), .cnt_flat(cnt_flat)
  );

  sr_entry_ram #(.ADDR_W(ADDR_W), .DATA_W(ENT_W)) u_ram (
    .clk(clk),
    .we(push), .waddr({rec_tid, own_wptr}), .wdata({rec_ts, rec_r, rec_w}),
    .re(rd_en), .raddr({cur_t, rd_slot}), .rdata(rdata)
  );

  sr_conflict #(.NUM_THREADS(NUM_THREADS), .CLK_W(CLK_W), .SIG_W(SIG_W)) u_cmp (
    .in_ts(rec_ts), .in_r(rec_r), .in_w(rec_w),
    .q_ts(q_ts), .q_r(q_r), .q_w(q_w),
    .ordered(cmp_ordered), .hit(cmp_hit), .sig(cmp_sig)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= SCAN_IDLE;
      rec_tid    <= '0;
      rec_ts     <= '0;
      rec_r      <= '0;
      rec_w      <= '0;
      cur_t      <= '0;
      cur_k      <= '0;
      pend       <= 1'b0;
      pend_last  <= 1'b0;
      pend_peer  <= '0;
      race_valid <= 1'b0;
      race_tid   <= '0;
      race_peer  <= '0;
      race_sig   <= '0;
      race_flag  <= '0;
      ovf_flag   <= '0;
      conf_sig   <= '0;
    end else begin
      race_valid <= 1'b0;
      case (st)
        SCAN_IDLE: begin
          if (in_valid) begin
            rec_tid <= in_tid;
            rec_ts  <= in_ts;
            rec_r   <= in_rsig;
            rec_w   <= in_wsig;
            cur_t   <= '0;
            cur_k   <= '0;
            pend    <= 1'b0;
            st      <= SCAN_WALK;
          end
        end
        SCAN_WALK: begin
          if (hit_now) begin
            race_valid <= 1'b1;
            race_tid   <= rec_tid;
            race_peer  <= pend_peer;
            race_sig   <= cmp_sig;
            race_flag[rec_tid] <= 1'b1;
            conf_sig[rec_tid*SIG_W +: SIG_W] <= conf_sig[rec_tid*SIG_W +: SIG_W] | cmp_sig;
          end
          if (thr_done) begin
            pend  <= 1'b0;
            cur_k <= '0;
            if (last_thr) st <= SCAN_PUSH;
            else          cur_t <= cur_t + TID_W'(1);
          end else begin
            pend      <= 1'b1;
            pend_last <= (cur_k + CNT_W'(1)) == eff_cnt;
            pend_peer <= cur_t;
            cur_k     <= cur_k + CNT_W'(1);
          end
        end
        SCAN_PUSH: begin
          if (own_cnt == CNT_W'(QDEPTH)) ovf_flag[rec_tid] <= 1'b1;
          st <= SCAN_IDLE;
        end
        default: st <= SCAN_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sr_race_checker.sv
module sr_race_checker #(
  parameter int NUM_THREADS = 4,
  parameter int SIG_W       = 64
) (
  input logic                                                 clk,
  input logic                                                 rst,
  input logic                                                 in_valid,
  input logic                                                 in_ready,
  input logic                                                 race_valid,
  input logic [((NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1)-1:0] race_tid,
  input logic [((NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1)-1:0] race_peer,
  input logic [SIG_W-1:0]                                     race_sig,
  input logic [NUM_THREADS-1:0]                               race_flag,
  input logic [NUM_THREADS-1:0]                               ovf_flag
);
  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // R6
  report_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    race_valid |-> !in_ready);

  // R5
  peer_not_self_chk: assert property (@(posedge clk) disable iff (rst)
    race_valid |-> (race_tid != race_peer));

  // R3
  nonempty_sig_chk: assert property (@(posedge clk) disable iff (rst)
    race_valid |-> (race_sig != '0));

  // R7
  flag_on_report_chk: assert property (@(posedge clk) disable iff (rst)
    race_valid |-> race_flag[race_tid]);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (race_flag & $past(race_flag)) == $past(race_flag));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag & $past(ovf_flag)) == $past(ovf_flag));
endmodule

bind sigrace_detector sr_race_checker #(
  .NUM_THREADS(NUM_THREADS), .SIG_W(SIG_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .race_valid(race_valid), .race_tid(race_tid), .race_peer(race_peer),
  .race_sig(race_sig), .race_flag(race_flag), .ovf_flag(ovf_flag)
);

// File: tb/sigrace_detector_test.sv
module sigrace_detector_test;
  localparam int NT   = 4;
  localparam int QD   = 4;
  localparam int SW   = 16;
  localparam int CW   = 4;
  localparam int TIDW = 2;
  localparam int TSW  = NT * CW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [TIDW-1:0] in_tid = '0;
  logic [TSW-1:0]  in_ts = '0;
  logic [SW-1:0]   in_rsig = '0, in_wsig = '0;
  logic            race_valid;
  logic [TIDW-1:0] race_tid, race_peer;
  logic [SW-1:0]   race_sig;
  logic [NT-1:0]   race_flag, ovf_flag;
  logic [NT*SW-1:0] conf_sig;

  always #2 clk = ~clk;

  sigrace_detector #(.NUM_THREADS(NT), .QDEPTH(QD), .SIG_W(SW), .CLK_W(CW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_tid(in_tid), .in_ts(in_ts), .in_rsig(in_rsig), .in_wsig(in_wsig),
    .race_valid(race_valid), .race_tid(race_tid), .race_peer(race_peer),
    .race_sig(race_sig), .race_flag(race_flag), .ovf_flag(ovf_flag),
    .conf_sig(conf_sig)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  // Reference history, index 0 is the oldest record
  logic [TSW-1:0] m_ts [NT][QD];
  logic [SW-1:0]  m_r  [NT][QD];
  logic [SW-1:0]  m_w  [NT][QD];
  int             m_n  [NT];
  logic [NT-1:0]  e_flag = '0;
  logic [NT-1:0]  e_ovf = '0;
  logic [SW-1:0]  e_conf [NT];
  logic [31:0]    exp_q [$];

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [TSW-1:0] vc(input int a0, input int a1, input int a2, input int a3);
    return {4'(a3), 4'(a2), 4'(a1), 4'(a0)};
  endfunction

  function automatic bit is_ordered(input logic [TSW-1:0] a, input logic [TSW-1:0] b);
    bit a_le = 1, b_le = 1;
    for (int i = 0; i < NT; i++) begin
      if (a[i*CW +: CW] > b[i*CW +: CW]) a_le = 0;
      if (b[i*CW +: CW] > a[i*CW +: CW]) b_le = 0;
    end
    return a_le || b_le;
  endfunction

  // Driver: predicts reports into the scoreboard, then offers the record
  task automatic send(input int tid, input logic [TSW-1:0] ts,
                      input logic [SW-1:0] r, input logic [SW-1:0] w);
    for (int t = 0; t < NT; t++) begin
      if (t == tid) continue;
      for (int k = m_n[t] - 1; k >= 0; k--) begin
        logic [SW-1:0] s;
        if (is_ordered(ts, m_ts[t][k])) break;
        s = (r & m_w[t][k]) | (w & m_w[t][k]) | (w & m_r[t][k]);
        if (s != '0) begin
          exp_q.push_back({8'(tid), 8'(t), s});
          e_flag[tid] = 1'b1;
          e_conf[tid] = e_conf[tid] | s;
        end
      end
    end
    if (m_n[tid] == QD) begin
      for (int k = 0; k < QD - 1; k++) begin
        m_ts[tid][k] = m_ts[tid][k+1];
        m_r[tid][k]  = m_r[tid][k+1];
        m_w[tid][k]  = m_w[tid][k+1];
      end
      m_n[tid] = QD - 1;
      e_ovf[tid] = 1'b1;
    end
    m_ts[tid][m_n[tid]] = ts;
    m_r[tid][m_n[tid]]  = r;
    m_w[tid][m_n[tid]]  = w;
    m_n[tid]++;

    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_tid   = TIDW'(tid);
    in_ts    = ts;
    in_rsig  = r;
    in_wsig  = w;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 ready low after accept", 64'(in_ready), 64'd0);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: pops the scoreboard on each report (R6)
  always @(negedge clk) begin
    if (!rst && race_valid) begin
      if (exp_q.size() == 0) begin
        n_checks++;
        n_fail++;
        $display("FAIL R6 unexpected report: got tid=%0d peer=%0d sig=%h expected none",
                 race_tid, race_peer, race_sig);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk("R6 report tid/peer/sig", {32'd0, 8'(race_tid), 8'(race_peer), race_sig}, {32'd0, e});
      end
    end
  end

  initial begin
    for (int t = 0; t < NT; t++) begin
      m_n[t] = 0;
      e_conf[t] = '0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 in_ready", 64'(in_ready), 64'd1);
    chk("R1 race_valid", 64'(race_valid), 64'd0);
    chk("R1 race_flag", 64'(race_flag), 64'd0);
    chk("R1 ovf_flag", 64'(ovf_flag), 64'd0);
    chk("R1 conf_sig", conf_sig, 64'd0);

    // T0 history: older entry writes 0x10, newer entry writes nothing
    send(0, vc(1,0,0,0), 16'h0001, 16'h0010);
    send(0, vc(2,0,0,0), 16'h0001, 16'h0000);
    // R4: newest T0 entry is ordered before this one, so the conflicting older entry is hidden
    send(3, vc(2,0,0,1), 16'h0000, 16'h0010);
    wait_idle();
    chk("R4 ordered entry stops walk", 64'(race_flag[3]), 64'd0);

    // R5: concurrent with all of T0 and T3; reports ordered by thread, then newest first
    send(1, vc(0,1,0,0), 16'h0010, 16'h0001);
    wait_idle();
    chk("R5 all reports seen in order", 64'(exp_q.size()), 64'd0);

    // R3: empty signatures never report
    send(2, vc(0,0,1,0), 16'h0000, 16'h0000);
    wait_idle();
    chk("R3 empty signatures", 64'(race_flag[2]), 64'd0);

    // R8: fill and overflow T2, dropping the entry that writes 0x8000
    send(2, vc(0,0,2,0), 16'h0000, 16'h8000);
    send(2, vc(0,0,3,0), 16'h0000, 16'h0000);
    send(2, vc(0,0,4,0), 16'h0000, 16'h0000);
    send(2, vc(0,0,5,0), 16'h0000, 16'h0000);
    send(2, vc(0,0,6,0), 16'h0000, 16'h0000);
    wait_idle();
    chk("R8 overflow flag", 64'(ovf_flag), 64'(4'b0100));
    send(1, vc(0,2,0,0), 16'h8000, 16'h0000);
    wait_idle();
    chk("R8 dropped entry not checked", 64'(conf_sig[1*SW + 15]), 64'd0);

    // Several hits in one walk across T0 and T1
    send(3, vc(0,0,0,2), 16'h0000, 16'h0001);
    // Equal timestamps count as ordered
    send(0, vc(0,0,0,2), 16'h0001, 16'h0001);
    wait_idle();

    chk("R6 scoreboard drained", 64'(exp_q.size()), 64'd0);
    chk("R7 race flags", 64'(race_flag), 64'(e_flag));
    chk("R8 overflow flags", 64'(ovf_flag), 64'(e_ovf));
    for (int t = 0; t < NT; t++)
      chk("R7 conflict signature", 64'(conf_sig[t*SW +: SW]), 64'(e_conf[t]));

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule